// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of page translations. Each slot holds a virtual page tag, a physical page number, an 8-bit address-space identifier, a global flag, per-privilege-mode read and write enable masks, and two fault-forcing flags (one for reads, one for writes). Address translation logic sits next to the buffer and presents a virtual page number and the current address-space identifier. In the same cycle it gets back a hit indication, the index of the hit slot, and that slot's payload. Page-table walking, permission decisions and fault reporting stay in that surrounding logic.

New translations come in through an insert port. Each one is written into the slot named by a round-robin replacement pointer, and the block exposes that pointer. Three invalidation commands share one command field: wipe every slot, drop only the slots not marked global, or drop the slots that match one page under the same global-or-identifier rule that lookups use. The depth is a parameter. An instruction-side instance is typically built with 48 slots and a data-side instance with 64.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, so no lookup hits, and the replacement pointer `ins_slot` is 0.
- R2: A lookup hits a slot only when the slot is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored identifier equals `lk_asn`.
- R3: The lookup outputs come from the buffer contents in the same cycle. On a hit, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd`, `lk_fault_wr` and `lk_global` carry the hit slot's stored values. On a miss they are all zero.
- R4: An accepted insert writes the slot named by `ins_slot` and overwrites whatever valid entry was there. The written slot becomes valid with tag `ins_vpn` and the supplied payload.
- R5: After each accepted insert the pointer advances by one and wraps from DEPTH-1 to 0. Nothing else moves it.
- R6: When several slots hit, the lowest index wins, and `lk_idx` reports that index.
- R7: `fl_cmd` = 2'b01 (wipe all) leaves every slot invalid on the next cycle.
- R8: `fl_cmd` = 2'b10 (drop non-global) invalidates exactly the slots whose global flag is clear. Global slots keep hitting afterwards.
- R9: `fl_cmd` = 2'b11 (drop one page) invalidates the slots whose tag equals `fl_vpn` and that are global or hold identifier `fl_asn`. All other slots stay valid.
- R10: Any nonzero `fl_cmd` takes priority over an insert in the same cycle. The insert is discarded and the pointer does not move.
- R11: An insert or invalidation becomes visible to lookups from the next cycle on. A lookup in the same cycle sees the previous contents. `fl_cmd` = 2'b00 means no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the winning slot |
| lk_ppn | output | PPN_W | Physical page of the hit slot |
| lk_rd_en | output | MODES | Read enable per mode of the hit slot |
| lk_wr_en | output | MODES | Write enable per mode of the hit slot |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit slot |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit slot |
| lk_global | output | 1 | Global flag of the hit slot |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Virtual page to store as tag |
| ins_ppn | input | PPN_W | Physical page to store |
| ins_asn | input | ASN_W | Identifier to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_en | input | MODES | Read enable mask to store |
| ins_wr_en | input | MODES | Write enable mask to store |
| ins_fault_rd | input | 1 | Fault-on-read flag to store |
| ins_fault_wr | input | 1 | Fault-on-write flag to store |
| fl_cmd | input | 2 | Invalidation command: 00 none, 01 all, 10 non-global, 11 one page |
| fl_vpn | input | VPN_W | Page for the one-page command |
| fl_asn | input | ASN_W | Identifier for the one-page command |
| ins_slot | output | IDX_W | Replacement pointer: the slot the next insert writes |

## Verification
The assertions check these on every cycle: the pointer stays in range, steps with wrap after an accepted insert, and holds whenever a command is present. An accepted insert lands valid in the pointed slot. Wiping leaves nothing valid. Dropping non-global entries leaves exactly the global slots that were valid. A one-page drop leaves no matching slot valid. Any reported hit is a real match. Only the bench scenarios can show that the hit rule is right, including identifier mismatches and global entries shared across identifiers. The same goes for the lowest-index choice between duplicate tags, overwriting after the pointer wraps, the payload values returned, and the one-cycle delay before an insert becomes visible.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
    localparam int TLB_ASN_W = 8;
    localparam int TLB_MODES = 4;

    typedef enum logic [1:0] {
        FL_NONE  = 2'b00,
        FL_ALL   = 2'b01,
        FL_LOCAL = 2'b10,
        FL_PAGE  = 2'b11
    } flush_cmd_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int DEPTH = 48,
    parameter int VPN_W = 30,
    parameter int ASN_W = 8
) (
    input  logic [DEPTH-1:0] ent_valid,
    input  logic [VPN_W-1:0] ent_tag [DEPTH],
    input  logic [ASN_W-1:0] ent_asn [DEPTH],
    input  logic [DEPTH-1:0] ent_glob,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [ASN_W-1:0] req_asn,
    output logic [DEPTH-1:0] hit_vec
);
    // Per-slot compare: tag equality plus (global or identifier equality)
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = ent_valid[i] && (ent_tag[i] == req_vpn) &&
                            (ent_glob[i] || (ent_asn[i] == req_asn));
    end
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is the last one written
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import asn_tlb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int VPN_W = 30,
    parameter int PPN_W = 28,
    parameter int ASN_W = 8,
    parameter int MODES = 4,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en_i,
    input  logic [VPN_W-1:0] ins_vpn_i,
    input  logic [PPN_W-1:0] ins_ppn_i,
    input  logic [ASN_W-1:0] ins_asn_i,
    input  logic             ins_glob_i,
    input  logic [MODES-1:0] ins_rd_i,
    input  logic [MODES-1:0] ins_wr_i,
    input  logic             ins_frd_i,
    input  logic             ins_fwr_i,
    input  flush_cmd_e       cmd_i,
    input  logic [DEPTH-1:0] page_kill_i,
    output logic [DEPTH-1:0] valid_o,
    output logic [DEPTH-1:0] glob_o,
    output logic [VPN_W-1:0] tag_o [DEPTH],
    output logic [ASN_W-1:0] asn_o [DEPTH],
    output logic [PPN_W-1:0] ppn_o [DEPTH],
    output logic [MODES-1:0] rd_o  [DEPTH],
    output logic [MODES-1:0] wr_o  [DEPTH],
    output logic [DEPTH-1:0] frd_o,
    output logic [DEPTH-1:0] fwr_o,
    output logic [IDX_W-1:0] ptr_o
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        logic [ASN_W-1:0] asn;
        logic             glob;
        logic [MODES-1:0] rd;
        logic [MODES-1:0] wr;
        logic             frd;
        logic             fwr;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [IDX_W-1:0]   ptr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd_i)
            FL_ALL: begin
                for (int i = 0; i < DEPTH; i++) st_d.ent[i] = '0;
            end
            FL_LOCAL: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (!st_q.ent[i].glob) st_d.ent[i].valid = 1'b0;
                end
            end
            FL_PAGE: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (page_kill_i[i]) st_d.ent[i].valid = 1'b0;
                end
            end
            default: begin
                // Insert is only accepted when no invalidation is pending
                if (ins_en_i) begin
                    st_d.ent[st_q.ptr] = '{valid: 1'b1, tag: ins_vpn_i, ppn: ins_ppn_i,
                                           asn: ins_asn_i, glob: ins_glob_i,
                                           rd: ins_rd_i, wr: ins_wr_i,
                                           frd: ins_frd_i, fwr: ins_fwr_i};
                    st_d.ptr = (st_q.ptr == LAST_SLOT) ? '0 : st_q.ptr + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign valid_o[i] = st_q.ent[i].valid;
        assign glob_o[i]  = st_q.ent[i].glob;
        assign tag_o[i]   = st_q.ent[i].tag;
        assign asn_o[i]   = st_q.ent[i].asn;
        assign ppn_o[i]   = st_q.ent[i].ppn;
        assign rd_o[i]    = st_q.ent[i].rd;
        assign wr_o[i]    = st_q.ent[i].wr;
        assign frd_o[i]   = st_q.ent[i].frd;
        assign fwr_o[i]   = st_q.ent[i].fwr;
    end
    assign ptr_o = st_q.ptr;

    wire ins_taken = ins_en_i && (cmd_i == FL_NONE);

    a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_o <= LAST_SLOT);

    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ins_taken |=> ptr_o == (($past(ptr_o) == LAST_SLOT) ? '0 : $past(ptr_o) + 1'b1));

    a_r10_cmd_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != FL_NONE) |=> $stable(ptr_o));

    a_r4_insert_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ins_taken |=> valid_o[$past(ptr_o)] && (tag_o[$past(ptr_o)] == $past(ins_vpn_i)));

    a_r7_wipe_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == FL_ALL) |=> (valid_o == '0));

    a_r8_globals_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == FL_LOCAL) |=> (valid_o == $past(valid_o & glob_o)));

    a_r9_page_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == FL_PAGE) |=> ((valid_o & $past(page_kill_i)) == '0));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import asn_tlb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int VPN_W = 30,
    parameter int PPN_W = 28,
    parameter int ASN_W = TLB_ASN_W,
    parameter int MODES = TLB_MODES,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr,
    output logic             lk_global,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_global,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr,
    input  logic [1:0]       fl_cmd,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    output logic [IDX_W-1:0] ins_slot
);
    logic [DEPTH-1:0] valid_v, glob_v, frd_v, fwr_v;
    logic [VPN_W-1:0] tag_a [DEPTH];
    logic [ASN_W-1:0] asn_a [DEPTH];
    logic [PPN_W-1:0] ppn_a [DEPTH];
    logic [MODES-1:0] rd_a  [DEPTH];
    logic [MODES-1:0] wr_a  [DEPTH];
    logic [DEPTH-1:0] lk_match, fl_match;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    flush_cmd_e       cmd;

    assign cmd = flush_cmd_e'(fl_cmd);

    tlb_entry_store #(
        .DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .ASN_W(ASN_W), .MODES(MODES), .IDX_W(IDX_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_en_i   (ins_en),
        .ins_vpn_i  (ins_vpn),
        .ins_ppn_i  (ins_ppn),
        .ins_asn_i  (ins_asn),
        .ins_glob_i (ins_global),
        .ins_rd_i   (ins_rd_en),
        .ins_wr_i   (ins_wr_en),
        .ins_frd_i  (ins_fault_rd),
        .ins_fwr_i  (ins_fault_wr),
        .cmd_i      (cmd),
        .page_kill_i(fl_match),
        .valid_o    (valid_v),
        .glob_o     (glob_v),
        .tag_o      (tag_a),
        .asn_o      (asn_a),
        .ppn_o      (ppn_a),
        .rd_o       (rd_a),
        .wr_o       (wr_a),
        .frd_o      (frd_v),
        .fwr_o      (fwr_v),
        .ptr_o      (ins_slot)
    );

    tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_cmp (
        .ent_valid(valid_v), .ent_tag(tag_a), .ent_asn(asn_a), .ent_glob(glob_v),
        .req_vpn(lk_vpn), .req_asn(lk_asn), .hit_vec(lk_match)
    );

    tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_cmp (
        .ent_valid(valid_v), .ent_tag(tag_a), .ent_asn(asn_a), .ent_glob(glob_v),
        .req_vpn(fl_vpn), .req_asn(fl_asn), .hit_vec(fl_match)
    );

    tlb_first_set #(.N(DEPTH), .IDX_W(IDX_W)) u_pick (
        .vec(lk_match), .any(any_hit), .idx(win_idx)
    );

    always_comb begin
        lk_hit      = any_hit;
        lk_idx      = any_hit ? win_idx : '0;
        lk_ppn      = '0;
        lk_rd_en    = '0;
        lk_wr_en    = '0;
        lk_fault_rd = 1'b0;
        lk_fault_wr = 1'b0;
        lk_global   = 1'b0;
        if (any_hit) begin
            lk_ppn      = ppn_a[win_idx];
            lk_rd_en    = rd_a[win_idx];
            lk_wr_en    = wr_a[win_idx];
            lk_fault_rd = frd_v[win_idx];
            lk_fault_wr = fwr_v[win_idx];
            lk_global   = glob_v[win_idx];
        end
    end

    a_r2_hit_is_real: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_v[lk_idx] && (tag_a[lk_idx] == lk_vpn) &&
                    (glob_v[lk_idx] || (asn_a[lk_idx] == lk_asn))));

    a_r1_clean_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (valid_v == '0) && (ins_slot == '0));
endmodule

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
    localparam int D = 8, VW = 20, PW = 16, AW = 8, MW = 4, IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [VW-1:0] lk_vpn = '0, ins_vpn = '0, fl_vpn = '0;
    logic [AW-1:0] lk_asn = '0, ins_asn = '0, fl_asn = '0;
    logic [PW-1:0] ins_ppn = '0, lk_ppn;
    logic [MW-1:0] ins_rd_en = '0, ins_wr_en = '0, lk_rd_en, lk_wr_en;
    logic ins_en = 1'b0, ins_global = 1'b0, ins_fault_rd = 1'b0, ins_fault_wr = 1'b0;
    logic [1:0] fl_cmd = 2'b00;
    logic lk_hit, lk_fault_rd, lk_fault_wr, lk_global;
    logic [IW-1:0] lk_idx, ins_slot;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    asn_tlb #(.DEPTH(D), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(MW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
        .lk_wr_en(lk_wr_en), .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
        .lk_global(lk_global), .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .ins_asn(ins_asn), .ins_global(ins_global), .ins_rd_en(ins_rd_en),
        .ins_wr_en(ins_wr_en), .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
        .fl_cmd(fl_cmd), .fl_vpn(fl_vpn), .fl_asn(fl_asn), .ins_slot(ins_slot)
    );

    // Behavioural reference: plain arrays updated on each rising edge
    bit m_v [D];
    bit m_g [D];
    bit m_fr [D];
    bit m_fw [D];
    int m_tag [D];
    int m_ppn [D];
    int m_asn [D];
    int m_rd [D];
    int m_wr [D];
    int m_ptr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) m_v[i] = 0;
            m_ptr = 0;
        end else if (fl_cmd == 2'b01) begin
            for (int i = 0; i < D; i++) begin
                m_v[i] = 0; m_g[i] = 0; m_tag[i] = 0; m_asn[i] = 0;
            end
        end else if (fl_cmd == 2'b10) begin
            for (int i = 0; i < D; i++) if (!m_g[i]) m_v[i] = 0;
        end else if (fl_cmd == 2'b11) begin
            for (int i = 0; i < D; i++)
                if (m_v[i] && m_tag[i] == int'(fl_vpn) && (m_g[i] || m_asn[i] == int'(fl_asn)))
                    m_v[i] = 0;
        end else if (ins_en) begin
            m_v[m_ptr] = 1; m_tag[m_ptr] = int'(ins_vpn); m_ppn[m_ptr] = int'(ins_ppn);
            m_asn[m_ptr] = int'(ins_asn); m_g[m_ptr] = ins_global;
            m_rd[m_ptr] = int'(ins_rd_en); m_wr[m_ptr] = int'(ins_wr_en);
            m_fr[m_ptr] = ins_fault_rd; m_fw[m_ptr] = ins_fault_wr;
            m_ptr = (m_ptr + 1) % D;
        end
    end

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic compare(input string rq);
        int w = -1;
        for (int i = D - 1; i >= 0; i--)
            if (m_v[i] && m_tag[i] == int'(lk_vpn) && (m_g[i] || m_asn[i] == int'(lk_asn))) w = i;
        chk(rq, "hit", lk_hit, (w >= 0));
        chk(rq, "slot", ins_slot, m_ptr);
        if (w >= 0) begin
            chk(rq, "idx", lk_idx, w);
            chk(rq, "ppn", lk_ppn, m_ppn[w]);
            chk(rq, "rd_en", lk_rd_en, m_rd[w]);
            chk(rq, "wr_en", lk_wr_en, m_wr[w]);
            chk(rq, "fault_rd", lk_fault_rd, m_fr[w]);
            chk(rq, "fault_wr", lk_fault_wr, m_fw[w]);
            chk(rq, "global", lk_global, m_g[w]);
        end else begin
            chk(rq, "ppn_zero", lk_ppn, 0);
            chk(rq, "rd_zero", lk_rd_en, 0);
        end
    endtask

    // Called at a falling edge with inputs already set; compares, then moves one cycle on
    task automatic cyc(input string rq);
        #1 compare(rq);
        @(negedge clk);
        ins_en = 1'b0; fl_cmd = 2'b00;
    endtask

    task automatic look(input int vpn, input int asn, input bit eh, input int ei, input string rq);
        lk_vpn = VW'(vpn); lk_asn = AW'(asn);
        #1 chk(rq, "lit_hit", lk_hit, eh);
        if (eh) chk(rq, "lit_idx", lk_idx, ei);
        cyc(rq);
    endtask

    task automatic put(input int vpn, input int ppn, input int asn, input bit g,
                       input int rd, input int wr, input bit fr, input bit fw, input string rq);
        ins_en = 1'b1; ins_vpn = VW'(vpn); ins_ppn = PW'(ppn); ins_asn = AW'(asn);
        ins_global = g; ins_rd_en = MW'(rd); ins_wr_en = MW'(wr);
        ins_fault_rd = fr; ins_fault_wr = fw;
        cyc(rq);
    endtask

    task automatic flush(input int cmd, input int vpn, input int asn, input string rq);
        fl_cmd = 2'(cmd); fl_vpn = VW'(vpn); fl_asn = AW'(asn);
        cyc(rq);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        #1 chk("R1", "hit_after_reset", lk_hit, 0);
        chk("R1", "slot_after_reset", ins_slot, 0);
        cyc("R1");

        // R11: lookup of the page being inserted misses in the insert cycle
        lk_vpn = 20'h111; lk_asn = 8'd1;
        ins_en = 1'b1; ins_vpn = 20'h111; ins_ppn = 16'h00A0; ins_asn = 8'd1; ins_global = 1'b0;
        ins_rd_en = 4'b0011; ins_wr_en = 4'b0001; ins_fault_rd = 1'b0; ins_fault_wr = 1'b1;
        #1 chk("R11", "same_cycle_miss", lk_hit, 0);
        cyc("R11");
        look('h111, 1, 1, 0, "R2");
        #1 chk("R3", "ppn_lit", lk_ppn, 16'h00A0);
        chk("R3", "rd_lit", lk_rd_en, 4'b0011);
        chk("R3", "fw_lit", lk_fault_wr, 1);
        cyc("R3");

        put('h222, 'hB0, 2, 1, 'hF, 'h3, 1, 0, "R4");
        put('h333, 'hC0, 3, 0, 'h1, 'h0, 0, 0, "R4");
        look('h111, 2, 0, 0, "R2");   // identifier mismatch, not global
        look('h222, 7, 1, 1, "R2");   // global entry hits any identifier
        look('h333, 3, 1, 2, "R2");

        // R6: duplicate page in slot 3, lowest index still wins
        put('h111, 'hA3, 1, 0, 'h2, 'h2, 1, 1, "R6");
        look('h111, 1, 1, 0, "R6");

        // R5: fill to the end and wrap
        for (int i = 4; i < D; i++) put('h400 + i, 'h40 + i, 4, 0, 'h1, 'h1, 0, 0, "R5");
        #1 chk("R5", "wrap_to_zero", ins_slot, 0);
        cyc("R5");

        // R4: overwrite slot 0
        put('h555, 'hD0, 1, 0, 'h4, 'h4, 0, 0, "R4");
        look('h111, 1, 1, 3, "R4");
        look('h555, 1, 1, 0, "R4");

        // R9: one-page drops
        flush(3, 'h111, 1, "R9");
        look('h111, 1, 0, 0, "R9");
        look('h555, 1, 1, 0, "R9");
        flush(3, 'h222, 9, "R9");     // global entry dropped under any identifier
        look('h222, 2, 0, 0, "R9");
        flush(3, 'h333, 5, "R9");     // wrong identifier, slot kept
        look('h333, 3, 1, 2, "R9");

        // R10: command beats simultaneous insert
        ins_en = 1'b1; ins_vpn = 20'h666; ins_ppn = 16'h0066; ins_asn = 8'd6; ins_global = 1'b0;
        flush(3, 'h777, 0, "R10");
        #1 chk("R10", "slot_held", ins_slot, 1);
        cyc("R10");
        look('h666, 6, 0, 0, "R10");

        // R8: drop non-global
        put('h888, 'h88, 6, 1, 'h5, 'h5, 0, 1, "R8");
        flush(2, 0, 0, "R8");
        look('h888, 0, 1, 1, "R8");
        look('h333, 3, 0, 0, "R8");
        look('h555, 1, 0, 0, "R8");
        look('h404, 4, 0, 0, "R8");

        // R7: wipe
        flush(1, 0, 0, "R7");
        look('h888, 6, 0, 0, "R7");
        look('h000, 0, 0, 0, "R7");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule